// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block turns activity on external pins into interrupt requests for a processor core. Three dedicated interrupt pins each have their own sense setting. Two of them can detect a low level, any edge, a falling edge or a rising edge. The third detects only a rising edge or only a falling edge. There are also two groups of eight pin-change inputs. Each group has an 8-bit mask, and any transition on a masked-in pin raises that group's single request.

Every pin passes through a two-flop synchronizer, so detection depends only on the pin level, whatever the pin's direction. An edge event or a pin-change event sets a sticky pending flag, and the matching acknowledge pulse clears it. A low-level request is not latched: it follows the synchronized pin. A request output is driven only when both the source's enable bit and the global interrupt-enable input are 1.

Software configures the block through a small synchronous register bus. A write takes effect at the clock edge where the write enable is sampled. Read data is combinational from the current address.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every register and pending flag is 0, every read returns 0, and no request is driven. The pin synchronizers reset to 1, so the pins are assumed high during reset.
- R2: The register map is as follows.
  - Address 0 is the enable register: bit 7 enables external 1, bit 6 external 0, bit 5 external 2, bit 4 pin-change group 1 and bit 3 pin-change group 0. Bit 2 is read-only and reads 0. Bits 1 and 0 are plain storage.
  - Address 1 is the sense register: bits 1:0 set external 0, bits 3:2 set external 1 and bit 4 sets external 2. Bits 7:5 read 0.
  - Addresses 2 and 3 are the masks for group 0 and group 1.
  - Address 4 reads the pending flags in bits 4:0, in vector order. Writes to address 4 are ignored.
  - Addresses 5 to 7 read 0.
- R3: A request output is 1 only while its enable bit is 1 and the global interrupt-enable input is 1.
- R4: The two-bit sense field of external 0 and 1 is encoded as follows: 00 is low level, 01 is any edge, 10 is falling edge and 11 is rising edge. A low-level request follows the synchronized pin and is not latched.
- R5: For external 2, sense bit 0 selects falling edge and 1 selects rising edge. It has no level mode.
- R6: Group 0 covers pin-change inputs 7..0 and group 1 covers 15..8. A transition on a pin whose mask bit is 1 sets the group's pending flag. A transition on an unmasked pin does nothing.
- R7: Pending flags are sticky and are set even while the source or the global enable is disabled. An acknowledge bit clears its own flag. A new event in the same cycle as the acknowledge wins.
- R8: An edge request appears after the third rising clock edge following a pin change. A level request appears after the second.
- R9: Request and acknowledge bits are in vector order: 0 is external 0, 1 is external 1, 2 is external 2, 3 is group 0 and 4 is group 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr |
| globalIe | input | 1 | Global interrupt enable |
| extPin | input | 3 | Dedicated interrupt pins 0..2 |
| pcPin | input | 16 | Pin-change inputs 15..0 |
| ack | input | 5 | Per-vector acknowledge pulses |
| irqReq | output | 5 | Per-vector request outputs |

## Verification
A wrong synchronizer or previous-value register shows up as a request that is one cycle early or late, or as a spurious request right after reset. A wrong sense decode or mask decode shows up as a missing or extra pending bit. This is visible on irqReq within three clocks of the pin change, and on the pending read at address 4 the cycle after it is set. A pending flag that drops without an acknowledge, or survives one, differs from the reference model on the next clock.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int NVEC = 5;
  localparam int VEC_EXT0 = 0;
  localparam int VEC_EXT1 = 1;
  localparam int VEC_EXT2 = 2;
  localparam int VEC_PC0  = 3;
  localparam int VEC_PC1  = 4;
  localparam int NUM_EXT  = 3;
  localparam int NUM_GRP  = 2;

  // bit positions of enables in the enable register
  localparam int EN_POS_EXT1 = 7;
  localparam int EN_POS_EXT0 = 6;
  localparam int EN_POS_EXT2 = 5;
  localparam int EN_POS_PC1  = 4;
  localparam int EN_POS_PC0  = 3;
  localparam int RO_ZERO_POS = 2;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  typedef struct packed {
    logic            wrCtl;
    logic            wrSense;
    logic            wrMask0;
    logic            wrMask1;
    logic [NVEC-1:0] setPend;
    logic [1:0]      levelHit;
  } strobe_t;
endpackage

// File: rtl/pin_irq_control.sv
module pin_irq_control
  import pin_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int GRP_W  = 8
) (
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [NUM_EXT-1:0]   extNow,
  input  logic [NUM_EXT-1:0]   extPrev,
  input  logic [2*GRP_W-1:0]   pcNow,
  input  logic [2*GRP_W-1:0]   pcPrev,
  input  logic [4:0]           senseReg,
  input  logic [2*GRP_W-1:0]   pcMask,
  output strobe_t              stb
);
  function automatic logic senseHit(input logic [1:0] mode, input logic now, input logic prev);
    case (sense_e'(mode))
      SENSE_LOW:  senseHit = 1'b0;
      SENSE_ANY:  senseHit = now ^ prev;
      SENSE_FALL: senseHit = prev & ~now;
      default:    senseHit = now & ~prev;
    endcase
  endfunction

  logic [NVEC-1:0] setPend;
  logic [1:0]      levelHit;

  // two-bit sensed sources
  for (genvar e = 0; e < 2; e++) begin : g_twoBit
    assign setPend[e]  = senseHit(senseReg[2*e +: 2], extNow[e], extPrev[e]);
    assign levelHit[e] = (sense_e'(senseReg[2*e +: 2]) == SENSE_LOW) & ~extNow[e];
  end

  // one-bit sensed source: edge only
  assign setPend[VEC_EXT2] = senseReg[4] ? (extNow[2] & ~extPrev[2])
                                         : (extPrev[2] & ~extNow[2]);

  // masked any-change groups
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_group
    assign setPend[VEC_PC0 + g] =
      |((pcNow[g*GRP_W +: GRP_W] ^ pcPrev[g*GRP_W +: GRP_W]) & pcMask[g*GRP_W +: GRP_W]);
  end

  always_comb begin
    stb          = '0;
    stb.setPend  = setPend;
    stb.levelHit = levelHit;
    if (busWrEn) begin
      case (busAddr)
        ADDR_W'(0): stb.wrCtl   = 1'b1;
        ADDR_W'(1): stb.wrSense = 1'b1;
        ADDR_W'(2): stb.wrMask0 = 1'b1;
        ADDR_W'(3): stb.wrMask1 = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int GRP_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic                 globalIe,
  input  logic [NUM_EXT-1:0]   extPin,
  input  logic [2*GRP_W-1:0]   pcPin,
  input  logic [NVEC-1:0]      ack,
  output logic [NVEC-1:0]      irqReq,
  output logic [NUM_EXT-1:0]   extNow,
  output logic [NUM_EXT-1:0]   extPrev,
  output logic [2*GRP_W-1:0]   pcNow,
  output logic [2*GRP_W-1:0]   pcPrev,
  output logic [4:0]           senseReg,
  output logic [2*GRP_W-1:0]   pcMask,
  output logic [NVEC-1:0]      pendQ
);
  localparam int PIN_W = NUM_EXT + 2*GRP_W;

  logic [PIN_W-1:0] syncStage [SYNC_STAGES];
  logic [PIN_W-1:0] prevQ;
  logic [DATA_W-1:0] ctlReg;
  logic [GRP_W-1:0]  mask0, mask1;
  logic [NVEC-1:0]   enVec;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      syncStage[s] <= '1;
      else if (s == 0) syncStage[s] <= {pcPin, extPin};
      else            syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '1;
    else       prevQ <= syncStage[SYNC_STAGES-1];
  end

  assign extNow  = syncStage[SYNC_STAGES-1][NUM_EXT-1:0];
  assign extPrev = prevQ[NUM_EXT-1:0];
  assign pcNow   = syncStage[SYNC_STAGES-1][PIN_W-1:NUM_EXT];
  assign pcPrev  = prevQ[PIN_W-1:NUM_EXT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg   <= '0;
      senseReg <= '0;
      mask0    <= '0;
      mask1    <= '0;
      pendQ    <= '0;
    end else begin
      if (stb.wrCtl)   ctlReg   <= busWrData & ~(DATA_W'(1) << RO_ZERO_POS);
      if (stb.wrSense) senseReg <= busWrData[4:0];
      if (stb.wrMask0) mask0    <= busWrData[GRP_W-1:0];
      if (stb.wrMask1) mask1    <= busWrData[GRP_W-1:0];
      pendQ <= (pendQ & ~ack) | stb.setPend;
    end
  end

  assign pcMask = {mask1, mask0};

  assign enVec[VEC_EXT0] = ctlReg[EN_POS_EXT0];
  assign enVec[VEC_EXT1] = ctlReg[EN_POS_EXT1];
  assign enVec[VEC_EXT2] = ctlReg[EN_POS_EXT2];
  assign enVec[VEC_PC0]  = ctlReg[EN_POS_PC0];
  assign enVec[VEC_PC1]  = ctlReg[EN_POS_PC1];

  assign irqReq = enVec & {NVEC{globalIe}} & (pendQ | {{(NVEC-2){1'b0}}, stb.levelHit});

  always_comb begin
    case (busAddr)
      ADDR_W'(0): busRdData = ctlReg;
      ADDR_W'(1): busRdData = DATA_W'(senseReg);
      ADDR_W'(2): busRdData = DATA_W'(mask0);
      ADDR_W'(3): busRdData = DATA_W'(mask1);
      ADDR_W'(4): busRdData = DATA_W'(pendQ);
      default:    busRdData = '0;
    endcase
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int GRP_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic                globalIe,
  input  logic [NUM_EXT-1:0]  extPin,
  input  logic [2*GRP_W-1:0]  pcPin,
  input  logic [NVEC-1:0]     ack,
  output logic [NVEC-1:0]     irqReq
);
  strobe_t              stb;
  logic [NUM_EXT-1:0]   extNow, extPrev;
  logic [2*GRP_W-1:0]   pcNow, pcPrev, pcMask;
  logic [4:0]           senseReg;
  logic [NVEC-1:0]      pendQ;

  pin_irq_control #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_ctl (
    .busAddr(busAddr), .busWrEn(busWrEn),
    .extNow(extNow), .extPrev(extPrev),
    .pcNow(pcNow), .pcPrev(pcPrev),
    .senseReg(senseReg), .pcMask(pcMask),
    .stb(stb)
  );

  pin_irq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRP_W(GRP_W),
                     .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .globalIe(globalIe), .extPin(extPin), .pcPin(pcPin),
    .ack(ack), .irqReq(irqReq),
    .extNow(extNow), .extPrev(extPrev), .pcNow(pcNow), .pcPrev(pcPrev),
    .senseReg(senseReg), .pcMask(pcMask), .pendQ(pendQ)
  );
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
  import pin_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              globalIe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdData,
  input logic [NVEC-1:0]   ack,
  input logic [NVEC-1:0]   irqReq,
  input logic [NVEC-1:0]   pendQ,
  input logic [NVEC-1:0]   setPend
);
  // R3: no request without the global enable
  a_r3_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    (|irqReq) |-> globalIe);

  // R2: read-only bit of the enable register
  a_r2_ro_bit: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(0)) |-> !busRdData[RO_ZERO_POS]);

  // R5: external 2 request is never level driven
  a_r5_edge_only: assert property (@(posedge clk) disable iff (!rstN)
    irqReq[VEC_EXT2] |-> pendQ[VEC_EXT2]);

  // R6: group requests come only from latched flags
  a_r6_group_latched: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq[VEC_PC1:VEC_PC0] & ~pendQ[VEC_PC1:VEC_PC0]) == 2'b00);

  // R7: flags hold until acknowledged
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (|(pendQ & ~ack)) |=> ((pendQ & $past(pendQ & ~ack)) == $past(pendQ & ~ack)));

  // R7: acknowledge clears when no new event
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (|(ack & ~setPend)) |=> ((pendQ & $past(ack & ~setPend)) == '0));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .globalIe(globalIe),
  .busAddr(busAddr), .busRdData(busRdData),
  .ack(ack), .irqReq(irqReq), .pendQ(pendQ), .setPend(stb.setPend)
);

// File: tb/sim_pin_irq_ctrl.sv
module sim_pin_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        globalIe = 1'b0;
  logic [2:0]  extPin = 3'b111;
  logic [15:0] pcPin = 16'hFFFF;
  logic [4:0]  ack = '0;
  logic [4:0]  irqReq;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R1";

  always #2 clk = ~clk;  // 250 MHz

  pin_irq_ctrl u0 (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .globalIe(globalIe),
    .extPin(extPin), .pcPin(pcPin), .ack(ack), .irqReq(irqReq));

  // reference model state
  logic [7:0]  mEn, mSense, mMask0, mMask1;
  logic [4:0]  mPend;
  logic [18:0] m1, m2, m3;

  function automatic logic [4:0] modelEn();
    return {mEn[4], mEn[3], mEn[5], mEn[7], mEn[6]};
  endfunction

  function automatic logic twoBitHit(logic [1:0] md, logic now, logic prev);
    if (md == 2'b01) return now != prev;
    if (md == 2'b10) return prev && !now;
    if (md == 2'b11) return now && !prev;
    return 1'b0;
  endfunction

  function automatic logic [4:0] expReq();
    logic [4:0] lvl;
    lvl = '0;
    lvl[0] = (mSense[1:0] == 2'b00) && !m2[0];
    lvl[1] = (mSense[3:2] == 2'b00) && !m2[1];
    return modelEn() & {5{globalIe}} & (mPend | lvl);
  endfunction

  function automatic logic [7:0] expRead(logic [2:0] a);
    case (a)
      3'd0: return mEn;
      3'd1: return mSense;
      3'd2: return mMask0;
      3'd3: return mMask1;
      3'd4: return {3'b000, mPend};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mEn = 0; mSense = 0; mMask0 = 0; mMask1 = 0; mPend = 0;
      m1 = '1; m2 = '1; m3 = '1;
    end else begin
      logic [4:0] ev;
      ev[0] = twoBitHit(mSense[1:0], m2[0], m3[0]);
      ev[1] = twoBitHit(mSense[3:2], m2[1], m3[1]);
      ev[2] = mSense[4] ? (m2[2] && !m3[2]) : (m3[2] && !m2[2]);
      ev[3] = |((m2[10:3] ^ m3[10:3]) & mMask0);
      ev[4] = |((m2[18:11] ^ m3[18:11]) & mMask1);
      mPend = (mPend & ~ack) | ev;
      if (busWrEn) begin
        case (busAddr)
          3'd0: mEn = busWrData & 8'hFB;
          3'd1: mSense = {3'b000, busWrData[4:0]};
          3'd2: mMask0 = busWrData;
          3'd3: mMask1 = busWrData;
          default: ;
        endcase
      end
      m3 = m2; m2 = m1; m1 = {pcPin, extPin};
    end
  end

  task automatic check(string tag, string what, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(curReq, "irqReq", {3'b000, irqReq}, {3'b000, expReq()});
      check(curReq, "busRdData", busRdData, expRead(busAddr));
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    step();
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a);
    busAddr = a;
    step();
  endtask

  task automatic pulseAck(logic [4:0] v);
    ack = v; step(); ack = '0;
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    // R1: reset state
    curReq = "R1";
    check("R1", "irqReq@reset", {3'b000, irqReq}, 8'h00);
    for (int a = 0; a < 8; a++) begin rd(3'(a)); check("R1", "reset read", busRdData, 8'h00); end

    // R2: register map, read-only bit, ignored pending write
    curReq = "R2";
    wr(3'd0, 8'hFF); rd(3'd0); check("R2", "enable reg", busRdData, 8'hFB);
    wr(3'd0, 8'h03); rd(3'd0); check("R2", "storage bits", busRdData, 8'h03);
    wr(3'd1, 8'hFF); rd(3'd1); check("R2", "sense reg", busRdData, 8'h1F);
    wr(3'd2, 8'hA5); wr(3'd3, 8'h5A);
    wr(3'd4, 8'h1F); rd(3'd4); check("R2", "pending write ignored", busRdData, 8'h00);
    rd(3'd6); check("R2", "unused addr", busRdData, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h00);

    // R3 and R7: pending set while disabled, request only with both enables
    curReq = "R3";
    wr(3'd1, 8'h01);          // ext0 any edge
    extPin[0] = 1'b0; step(4);
    rd(3'd4); check("R7", "pending while disabled", busRdData, 8'h01);
    check("R3", "no req disabled", {3'b000, irqReq}, 8'h00);
    globalIe = 1'b1; step();
    check("R3", "global only", {3'b000, irqReq}, 8'h00);
    wr(3'd0, 8'h40); step();
    check("R3", "both enables", {3'b000, irqReq}, 8'h01);
    globalIe = 1'b0; step();
    check("R3", "global off", {3'b000, irqReq}, 8'h00);
    globalIe = 1'b1;
    curReq = "R7";
    pulseAck(5'b00001); step();
    check("R7", "ack cleared", {3'b000, irqReq}, 8'h00);

    // R8: edge latency
    curReq = "R8";
    extPin[0] = 1'b1;         // pin changes at negedge+1
    step(2); check("R8", "edge after 2 clocks", {3'b000, irqReq}, 8'h00);
    step(1); check("R8", "edge after 3 clocks", {3'b000, irqReq}, 8'h01);
    pulseAck(5'b00001); step();

    // R4: modes of ext0 and ext1
    curReq = "R4";
    wr(3'd0, 8'hC0);
    wr(3'd1, 8'b0000_1110);   // ext0 falling, ext1 rising
    extPin[1:0] = 2'b10; step(4);   // ext1 stays high, ext0 falls
    check("R4", "falling ext0", {3'b000, irqReq}, 8'h01);
    pulseAck(5'b00001); extPin[1] = 1'b0; step(4);
    check("R4", "falling ignored on rising ext1", {3'b000, irqReq}, 8'h00);
    extPin[1] = 1'b1; step(4);
    check("R4", "rising ext1", {3'b000, irqReq}, 8'h02);
    pulseAck(5'b00010);
    wr(3'd1, 8'h00);          // both level
    step(); check("R4", "level low ext0", {3'b000, irqReq}, 8'h01);
    extPin[0] = 1'b1;
    curReq = "R8";
    step(1); check("R8", "level after 1", {3'b000, irqReq}, 8'h01);
    step(1); check("R8", "level after 2", {3'b000, irqReq}, 8'h00);
    curReq = "R4";
    extPin[1] = 1'b0; step(3);
    check("R4", "level ext1 not latched", {3'b000, irqReq}, 8'h02);
    extPin[1] = 1'b1; step(3);
    check("R4", "level released", {3'b000, irqReq}, 8'h00);
    wr(3'd0, 8'h00);

    // R5: ext2 edge only
    curReq = "R5";
    wr(3'd0, 8'h20); wr(3'd1, 8'h10);  // rising
    extPin[2] = 1'b0; step(4);
    check("R5", "fall ignored in rising mode", {3'b000, irqReq}, 8'h00);
    extPin[2] = 1'b1; step(4);
    check("R5", "rising ext2", {3'b000, irqReq}, 8'h04);
    pulseAck(5'b00100); wr(3'd1, 8'h00);
    extPin[2] = 1'b0; step(4);
    check("R5", "falling ext2", {3'b000, irqReq}, 8'h04);
    pulseAck(5'b00100); step(4);
    check("R5", "no level on low pin", {3'b000, irqReq}, 8'h00);
    extPin[2] = 1'b1; step(4); wr(3'd0, 8'h00);

    // R6: pin-change groups
    curReq = "R6";
    wr(3'd0, 8'h18); wr(3'd2, 8'h04); wr(3'd3, 8'h80);
    pcPin[3] = 1'b0; step(4);
    check("R6", "unmasked pin ignored", {3'b000, irqReq}, 8'h00);
    pcPin[2] = 1'b0; step(4);
    check("R6", "group0 masked pin", {3'b000, irqReq}, 8'h08);
    pulseAck(5'b01000);
    pcPin[15] = 1'b0; step(4);
    check("R6", "group1 masked pin", {3'b000, irqReq}, 8'h10);
    pulseAck(5'b10000);
    pcPin[15] = 1'b1; step(4);
    check("R6", "group1 rising change", {3'b000, irqReq}, 8'h10);

    // R7: event beats simultaneous ack
    curReq = "R7";
    pcPin[15] = 1'b0; step(2);   // event strobe live during next clock
    pulseAck(5'b10000); step();
    check("R7", "set wins over ack", {3'b000, irqReq}, 8'h10);
    pulseAck(5'b10000); step();

    // R9: mixed random traffic, full model compare every clock
    curReq = "R9";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) extPin = extPin ^ 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) pcPin = pcPin ^ (16'h1 << $urandom_range(0, 15));
      ack = 5'($urandom_range(0, 31)) & 5'($urandom_range(0, 31));
      if ($urandom_range(0, 15) == 0) globalIe = ~globalIe;
      busWrEn = ($urandom_range(0, 7) == 0);
      busAddr = 3'($urandom_range(0, 7));
      busWrData = 8'($urandom_range(0, 255));
      step();
    end
    busWrEn = 1'b0; ack = '0;
    step(2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #200000;
    total++; fails++;
    $display("FAIL watchdog expired during %s", curReq);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule